// File: doc/BRIEF.md
# Timer-Referenced Capture/Compare Channel Array

This block is a bank of capture/compare channels that sit beside two free-running 16-bit time bases. The counters are outside the block. Each channel holds one value register and one small configuration register. Each channel picks which of the two time bases it follows. It then works in one of two ways. In capture mode it records the chosen timer's value when its input pin changes. In compare mode it watches the chosen timer, and on a match it raises an event, changes its output pin, or does both. Two of the compare modes allow only one event per timer period. They re-arm when the allocated timer signals its overflow.

Software reaches the channels through a simple write port and a registered read port. Each channel has a sticky interrupt flag, and a write with set mask bits clears it. A pairing option lets a lower channel n and an upper channel n+N/2 drive one pin together. Either register's match then toggles that pin, which gives two edges per period from a single output.

Top module: `tmr_ccx_array`

## Requirements
- R1: A write with `wr_sel`=0 loads the value register of channel `wr_ch`, and `wr_sel`=1 loads its 5-bit configuration. `rd_data` is registered: one edge after `rd_sel`/`rd_ch` are applied it shows the value (`rd_sel`=0), the configuration zero-extended (`rd_sel`=1) or the flag vector zero-extended (`rd_sel`=2). After reset all value, configuration and flag state reads 0.
- R2: Configuration bit 3 picks the channel's time base (0 = timer A, 1 = timer B). Matches and overflows of the other timer have no effect on the channel.
- R3: In a capture mode, a pin transition applied before edge k is detected through a two-flop synchronizer. At edge k+2 the selected timer's value is latched into the value register and the channel flag is set. When nothing is captured or written, the value register holds.
- R4: Mode field bits [2:0]: 0 = disabled, 1 = capture on a rising edge, 2 = capture on a falling edge, 3 = capture on both edges. A transition the mode does not select captures nothing and sets no flag.
- R5: A compare match happens only on an edge where the selected timer's value differs from its value one edge earlier and equals the channel value. The result appears at that edge. A timer that stays at the matching value raises no further events.
- R6: Mode 4 sets the channel flag on every match and leaves the pin undriven (`pin_oe`=0, `pin_out`=0). Several matches per period are allowed.
- R7: Mode 5 drives the pin (`pin_oe`=1), toggles `pin_out` on every match and sets the flag on every match.
- R8: Mode 6 sets the flag on the first match only. Later matches are ignored until the allocated timer's overflow strobe re-arms the channel. A match on the same edge as that overflow counts as the first event of the new period.
- R9: Mode 7 drives the pin and sets it to 1 on the first match of a period, with the flag. The allocated timer's overflow clears the pin to 0. A match on the same edge as the overflow wins and leaves the pin at 1. There is one event per period, as in R8.
- R10: Configuration bit 4 on a lower channel n (n < N/2) in mode 5 pairs it with channel n+N/2. A compare event of either channel toggles pin n. Two events on the same edge give a single toggle. While paired, the upper channel's pin is not driven.
- R11: Flags are sticky. A write with `wr_sel`=2 clears every flag whose bit in `wr_data` is 1 and leaves the others alone. An event on the same edge as its clear leaves the flag set.
- R12: A configuration write to a channel clears its pin output and re-arms its once-per-period lock. In a disabled channel the pin is undriven and matches set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_a | input | 16 | Time base A current value |
| ovf_a | input | 1 | Time base A overflow strobe |
| tmr_b | input | 16 | Time base B current value |
| ovf_b | input | 1 | Time base B overflow strobe |
| pin_in | input | 8 | Per-channel capture inputs (asynchronous) |
| pin_out | output | 8 | Per-channel compare outputs |
| pin_oe | output | 8 | Per-channel output enables |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 value, 1 configuration, 2 flag clear |
| wr_ch | input | 3 | Channel addressed by a write |
| wr_data | input | 16 | Write data or flag clear mask |
| rd_sel | input | 2 | Read source: 0 value, 1 configuration, 2 flags |
| rd_ch | input | 3 | Channel addressed by a read |
| rd_data | output | 16 | Registered read data |
| irq | output | 8 | Per-channel sticky interrupt flags |

## Verification
Compare results are due on the single edge that samples the new timer value. Capture results are due on the third edge after the pin is driven, and read data one edge after the address is applied. The bench drives every input on the falling clock edge, advances a counted number of rising edges, and samples on the following falling edge. Because of this, each check lands in the exact cycle its requirement names. For captures, the bench also samples one edge early and expects no result there, which pins the synchronizer depth. Re-arm and pairing checks hold the timers still between steps, so each check can only be caused by the step just taken.

// File: rtl/ccx_pkg.sv
package ccx_pkg;

  typedef enum logic [2:0] {
    M_OFF        = 3'd0,
    M_CAP_RISE   = 3'd1,
    M_CAP_FALL   = 3'd2,
    M_CAP_BOTH   = 3'd3,
    M_CMP_EVT    = 3'd4,
    M_CMP_TGL    = 3'd5,
    M_CMP_ONCE   = 3'd6,
    M_CMP_SETCLR = 3'd7
  } ccx_mode_e;

  typedef struct packed {
    logic      pair;
    logic      tsel;
    ccx_mode_e mode;
  } ccx_cfg_t;

  localparam int CFGW = $bits(ccx_cfg_t);

  localparam logic [1:0] SEL_VAL  = 2'd0;
  localparam logic [1:0] SEL_CFG  = 2'd1;
  localparam logic [1:0] SEL_FLAG = 2'd2;

  function automatic logic is_cmp(input ccx_mode_e m);
    return m[2];
  endfunction

  function automatic logic is_once(input ccx_mode_e m);
    return (m == M_CMP_ONCE) || (m == M_CMP_SETCLR);
  endfunction

  function automatic logic drives_pin(input ccx_mode_e m);
    return (m == M_CMP_TGL) || (m == M_CMP_SETCLR);
  endfunction

endpackage

// File: rtl/ccx_insync.sv
module ccx_insync #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] rise,
  output logic [NCH-1:0] fall
);

  logic [NCH-1:0] meta_q;
  logic [NCH-1:0] sync_q;
  logic [NCH-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise = sync_q & ~last_q;
  assign fall = ~sync_q & last_q;

endmodule

// File: rtl/ccx_chan.sv
module ccx_chan
  import ccx_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ccx_cfg_t      cfg,
  input  logic [TW-1:0] tmr,
  input  logic          tmr_chg,
  input  logic          tmr_ovf,
  input  logic          rise,
  input  logic          fall,
  input  logic          wr_val,
  input  logic          wr_cfg,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] val,
  output logic          cmp_evt,
  output logic          cap_evt
);

  logic [TW-1:0] val_q;
  logic          lock_q;
  logic          hit;

  // a match needs a fresh timer value, so a stalled count stays quiet
  assign hit = is_cmp(cfg.mode) && tmr_chg && (tmr == val_q);

  // the overflow of the allocated timer re-opens the period in the same cycle
  assign cmp_evt = hit && (!is_once(cfg.mode) || !lock_q || tmr_ovf);

  always_comb begin
    unique case (cfg.mode)
      M_CAP_RISE: cap_evt = rise;
      M_CAP_FALL: cap_evt = fall;
      M_CAP_BOTH: cap_evt = rise | fall;
      default:    cap_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
    end else if (wr_val) begin
      val_q <= wdata;
    end else if (cap_evt) begin
      val_q <= tmr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
    end else if (wr_cfg || !is_once(cfg.mode)) begin
      lock_q <= 1'b0;
    end else if (cmp_evt) begin
      lock_q <= 1'b1;
    end else if (tmr_ovf) begin
      lock_q <= 1'b0;
    end
  end

  assign val = val_q;

endmodule

// File: rtl/tmr_ccx_array.sv
module tmr_ccx_array
  import ccx_pkg::*;
#(
  parameter int NCH = 8,
  parameter int TW  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [TW-1:0]          tmr_a,
  input  logic                   ovf_a,
  input  logic [TW-1:0]          tmr_b,
  input  logic                   ovf_b,
  input  logic [NCH-1:0]         pin_in,
  output logic [NCH-1:0]         pin_out,
  output logic [NCH-1:0]         pin_oe,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [$clog2(NCH)-1:0] wr_ch,
  input  logic [TW-1:0]          wr_data,
  input  logic [1:0]             rd_sel,
  input  logic [$clog2(NCH)-1:0] rd_ch,
  output logic [TW-1:0]          rd_data,
  output logic [NCH-1:0]         irq
);

  localparam int CW   = $clog2(NCH);
  localparam int HALF = NCH / 2;

  logic [TW-1:0]  prev_a_q;
  logic [TW-1:0]  prev_b_q;
  logic           chg_a;
  logic           chg_b;

  ccx_cfg_t       cfg_q   [NCH];
  logic [TW-1:0]  val_arr [NCH];
  logic [TW-1:0]  tsel_val[NCH];
  logic [NCH-1:0] chg_sel;
  logic [NCH-1:0] ovf_sel;
  logic [NCH-1:0] wr_val_v;
  logic [NCH-1:0] wr_cfg_v;
  logic [NCH-1:0] cmp_evt;
  logic [NCH-1:0] cap_evt;
  logic [NCH-1:0] rise;
  logic [NCH-1:0] fall;
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] clr_mask;
  logic [HALF-1:0] pair_act;
  logic [TW-1:0]  rd_q;

  logic [NCH*TW-1:0]   val_flat;
  logic [NCH*CFGW-1:0] cfg_flat;

  // previous timer samples; loaded during reset as well so no false change shows afterwards
  always_ff @(posedge clk) begin
    prev_a_q <= tmr_a;
    prev_b_q <= tmr_b;
  end

  assign chg_a = (tmr_a != prev_a_q);
  assign chg_b = (tmr_b != prev_b_q);

  ccx_insync #(.NCH(NCH)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_in (pin_in),
    .rise   (rise),
    .fall   (fall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) cfg_q[i] <= '0;
    end else if (wr_en && (wr_sel == SEL_CFG)) begin
      cfg_q[wr_ch] <= ccx_cfg_t'(wr_data[CFGW-1:0]);
    end
  end

  assign clr_mask = (wr_en && (wr_sel == SEL_FLAG)) ? wr_data[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~clr_mask) | cmp_evt | cap_evt;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign tsel_val[i] = cfg_q[i].tsel ? tmr_b : tmr_a;
    assign chg_sel[i]  = cfg_q[i].tsel ? chg_b : chg_a;
    assign ovf_sel[i]  = cfg_q[i].tsel ? ovf_b : ovf_a;
    assign wr_val_v[i] = wr_en && (wr_sel == SEL_VAL) && (wr_ch == CW'(i));
    assign wr_cfg_v[i] = wr_en && (wr_sel == SEL_CFG) && (wr_ch == CW'(i));

    ccx_chan #(.TW(TW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .cfg     (cfg_q[i]),
      .tmr     (tsel_val[i]),
      .tmr_chg (chg_sel[i]),
      .tmr_ovf (ovf_sel[i]),
      .rise    (rise[i]),
      .fall    (fall[i]),
      .wr_val  (wr_val_v[i]),
      .wr_cfg  (wr_cfg_v[i]),
      .wdata   (wr_data),
      .val     (val_arr[i]),
      .cmp_evt (cmp_evt[i]),
      .cap_evt (cap_evt[i])
    );

    assign val_flat[i*TW +: TW]     = val_arr[i];
    assign cfg_flat[i*CFGW +: CFGW] = cfg_q[i];

    logic pin_r;
    logic slaved;
    logic toggle;

    if (i < HALF) begin : g_low
      assign pair_act[i] = cfg_q[i].pair && (cfg_q[i].mode == M_CMP_TGL);
      assign slaved      = 1'b0;
      // one toggle even if both registers match on the same edge
      assign toggle      = ((cfg_q[i].mode == M_CMP_TGL) && cmp_evt[i]) ||
                           (pair_act[i] && cmp_evt[i+HALF]);
    end else begin : g_high
      assign slaved = pair_act[i-HALF];
      assign toggle = (cfg_q[i].mode == M_CMP_TGL) && cmp_evt[i];
    end

    always_ff @(posedge clk) begin
      if (rst || wr_cfg_v[i] || slaved) begin
        pin_r <= 1'b0;
      end else begin
        unique case (cfg_q[i].mode)
          M_CMP_TGL:    pin_r <= pin_r ^ toggle;
          M_CMP_SETCLR: begin
            if (cmp_evt[i])      pin_r <= 1'b1;
            else if (ovf_sel[i]) pin_r <= 1'b0;
          end
          default:      pin_r <= 1'b0;
        endcase
      end
    end

    assign pin_out[i] = pin_r;
    assign pin_oe[i]  = drives_pin(cfg_q[i].mode) && !slaved;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      unique case (rd_sel)
        SEL_VAL:  rd_q <= val_arr[rd_ch];
        SEL_CFG:  rd_q <= {{(TW-CFGW){1'b0}}, cfg_q[rd_ch]};
        SEL_FLAG: rd_q <= {{(TW-NCH){1'b0}}, flag_q};
        default:  rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign irq     = flag_q;

endmodule

// File: rtl/ccx_chk.sv
module ccx_chk
  import ccx_pkg::*;
#(
  parameter int NCH = 8,
  parameter int TW  = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [TW-1:0]          tmr_a,
  input logic [TW-1:0]          tmr_b,
  input logic                   ovf_a,
  input logic                   ovf_b,
  input logic                   wr_en,
  input logic [1:0]             wr_sel,
  input logic [$clog2(NCH)-1:0] wr_ch,
  input logic [TW-1:0]          wr_data,
  input logic [NCH-1:0]         irq,
  input logic [NCH-1:0]         pin_out,
  input logic [NCH-1:0]         cmp_evt,
  input logic [NCH-1:0]         cap_evt,
  input logic [NCH*TW-1:0]      val_flat,
  input logic [NCH*CFGW-1:0]    cfg_flat
);

  localparam int CW = $clog2(NCH);

  logic [NCH-1:0] clr;
  assign clr = (wr_en && (wr_sel == SEL_FLAG)) ? wr_data[NCH-1:0] : '0;

  // R11: a flag that was set and not cleared stays set
  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq & ($past(irq) & ~$past(clr))) == ($past(irq) & ~$past(clr))));

  // R5: both timers unchanged since the last edge means no compare event
  p_stall_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    ((tmr_a == $past(tmr_a)) && (tmr_b == $past(tmr_b))) |-> (cmp_evt == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_c
    ccx_cfg_t c;
    logic     ovf_i;
    logic     wval_i;
    logic     wcfg_i;
    assign c      = ccx_cfg_t'(cfg_flat[i*CFGW +: CFGW]);
    assign ovf_i  = c.tsel ? ovf_b : ovf_a;
    assign wval_i = wr_en && (wr_sel == SEL_VAL) && (wr_ch == CW'(i));
    assign wcfg_i = wr_en && (wr_sel == SEL_CFG) && (wr_ch == CW'(i));

    // R3: the value register changes only by capture or write
    p_val_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!cap_evt[i] && !wval_i) |=> (val_flat[i*TW +: TW] == $past(val_flat[i*TW +: TW])));

    // R8: after a once-per-period event, another needs an overflow of the allocated timer
    p_once_lock_r8: assert property (@(posedge clk) disable iff (rst)
      (cmp_evt[i] && is_once(c.mode) && !wcfg_i) |=> (!cmp_evt[i] || ovf_i));

    // R9: an overflow without a match leaves a set/clear pin low
    p_setclr_ovf_r9: assert property (@(posedge clk) disable iff (rst)
      ((c.mode == M_CMP_SETCLR) && ovf_i && !cmp_evt[i]) |=> !pin_out[i]);
  end

endmodule

bind tmr_ccx_array ccx_chk #(.NCH(NCH), .TW(TW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .tmr_a    (tmr_a),
  .tmr_b    (tmr_b),
  .ovf_a    (ovf_a),
  .ovf_b    (ovf_b),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_ch    (wr_ch),
  .wr_data  (wr_data),
  .irq      (irq),
  .pin_out  (pin_out),
  .cmp_evt  (cmp_evt),
  .cap_evt  (cap_evt),
  .val_flat (val_flat),
  .cfg_flat (cfg_flat)
);

// File: tb/tmr_ccx_array_tb_top.sv
`timescale 1ns/1ps
module tmr_ccx_array_tb_top;

  localparam int NCH = 8;
  localparam int TW  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] ta = '0, tb = '0;
  logic          ova = 1'b0, ovb = 1'b0;
  logic [NCH-1:0] pin_in = '0;
  logic [NCH-1:0] pin_out, pin_oe, irq;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0, rd_sel = '0;
  logic [2:0]    wr_ch = '0, rd_ch = '0;
  logic [TW-1:0] wr_data = '0;
  logic [TW-1:0] rd_data;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  tmr_ccx_array #(.NCH(NCH), .TW(TW)) dut_i (
    .clk(clk), .rst(rst), .tmr_a(ta), .ovf_a(ova), .tmr_b(tb), .ovf_b(ovb),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_ch(rd_ch), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wreg(input logic [1:0] s, input logic [2:0] ch, input logic [TW-1:0] d);
    wr_en = 1'b1; wr_sel = s; wr_ch = ch; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] s, input logic [2:0] ch, output logic [TW-1:0] d);
    rd_sel = s; rd_ch = ch;
    tick();
    d = rd_data;
  endtask

  task automatic clr(input logic [NCH-1:0] m);
    wreg(2'd2, 3'd0, {{(TW-NCH){1'b0}}, m});
  endtask

  task automatic set_a(input logic [TW-1:0] v); ta = v; tick(); endtask
  task automatic set_b(input logic [TW-1:0] v); tb = v; tick(); endtask

  task automatic t_reset();
    logic [TW-1:0] d;
    chk("R1 reset irq", irq, 0);
    chk("R12 reset oe", pin_oe, 0);
    chk("R12 reset pin", pin_out, 0);
    rreg(2'd2, 3'd0, d); chk("R1 reset flags read", d, 0);
    rreg(2'd1, 3'd5, d); chk("R1 reset cfg read", d, 0);
    rreg(2'd0, 3'd7, d); chk("R1 reset val read", d, 0);
  endtask

  task automatic t_regs();
    logic [TW-1:0] d;
    wreg(2'd0, 3'd3, 16'hBEEF);
    rreg(2'd0, 3'd3, d); chk("R1 value readback", d, 16'hBEEF);
    wreg(2'd1, 3'd3, 16'h000C);
    rreg(2'd1, 3'd3, d); chk("R1 cfg readback", d, 16'h000C);
    wreg(2'd1, 3'd3, 16'h0000);
  endtask

  task automatic t_cmp_evt();
    wreg(2'd0, 3'd0, 16'h0010);
    wreg(2'd1, 3'd0, 16'h0004);
    set_a(16'h0010);
    chk("R6 match flag", irq[0], 1);
    chk("R6 pin undriven", pin_oe[0], 0);
    clr(8'h01);
    tick(3);
    chk("R5 stalled timer no retrigger", irq[0], 0);
    set_a(16'h0011); set_a(16'h0010);
    chk("R6 second match in period", irq[0], 1);
    clr(8'h01);
  endtask

  task automatic t_cmp_tgl();
    wreg(2'd0, 3'd1, 16'h0020);
    wreg(2'd1, 3'd1, 16'h000D);
    chk("R7 oe on", pin_oe[1], 1);
    set_a(16'h0020);
    chk("R2 other timer ignored pin", pin_out[1], 0);
    chk("R2 other timer ignored flag", irq[1], 0);
    set_b(16'h0020);
    chk("R7 first toggle", pin_out[1], 1);
    chk("R7 flag", irq[1], 1);
    set_b(16'h0021); set_b(16'h0020);
    chk("R7 second toggle", pin_out[1], 0);
  endtask

  task automatic t_cmp_once();
    wreg(2'd0, 3'd2, 16'h0030);
    wreg(2'd1, 3'd2, 16'h0006);
    set_a(16'h0030);
    chk("R8 first match", irq[2], 1);
    clr(8'h04);
    set_a(16'h0031); set_a(16'h0030);
    chk("R8 locked", irq[2], 0);
    ovb = 1'b1; tick(); ovb = 1'b0;
    set_a(16'h0031); set_a(16'h0030);
    chk("R2 other overflow no rearm", irq[2], 0);
    set_a(16'h0031);
    ta = 16'h0030; ova = 1'b1; tick(); ova = 1'b0;
    chk("R8 match with overflow", irq[2], 1);
    clr(8'h04);
    set_a(16'h0031); set_a(16'h0030);
    chk("R8 relocked", irq[2], 0);
    ta = 16'h0000; ova = 1'b1; tick(); ova = 1'b0;
    set_a(16'h0030);
    chk("R8 rearmed by overflow", irq[2], 1);
  endtask

  task automatic t_cmp_setclr();
    wreg(2'd0, 3'd3, 16'h0040);
    wreg(2'd1, 3'd3, 16'h000F);
    set_b(16'h0040);
    chk("R9 set on match", pin_out[3], 1);
    chk("R9 oe", pin_oe[3], 1);
    chk("R9 flag", irq[3], 1);
    clr(8'h08);
    set_b(16'h0041); set_b(16'h0040);
    chk("R9 one event per period", irq[3], 0);
    ova = 1'b1; tick(); ova = 1'b0;
    chk("R2 other overflow keeps pin", pin_out[3], 1);
    tb = 16'h0000; ovb = 1'b1; tick(); ovb = 1'b0;
    chk("R9 cleared on overflow", pin_out[3], 0);
    set_b(16'h0040);
    chk("R9 set again", pin_out[3], 1);
    tb = 16'h0000; ovb = 1'b1; tick(); ovb = 1'b0;
    set_b(16'h0041);
    tb = 16'h0040; ovb = 1'b1; tick(); ovb = 1'b0;
    chk("R9 match wins over overflow", pin_out[3], 1);
  endtask

  task automatic t_cfg();
    wreg(2'd1, 3'd3, 16'h0000);
    chk("R12 cfg write clears pin", pin_out[3], 0);
    chk("R12 disabled oe", pin_oe[3], 0);
    clr(8'h08);
    set_b(16'h0041); set_b(16'h0040);
    chk("R12 disabled no flag", irq[3], 0);
  endtask

  task automatic t_cap();
    logic [TW-1:0] d;
    wreg(2'd1, 3'd4, 16'h0001);
    set_a(16'h0155);
    pin_in[4] = 1'b1;
    tick(2);
    chk("R3 not yet captured", irq[4], 0);
    tick(1);
    chk("R3 capture flag", irq[4], 1);
    rreg(2'd0, 3'd4, d); chk("R3 captured value", d, 16'h0155);
    clr(8'h10);
    set_a(16'h0166);
    pin_in[4] = 1'b0;
    tick(4);
    chk("R4 falling ignored in rise mode", irq[4], 0);
    rreg(2'd0, 3'd4, d); chk("R4 value kept", d, 16'h0155);
    wreg(2'd1, 3'd5, 16'h000B);
    set_b(16'h0222);
    pin_in[5] = 1'b1; tick(3);
    chk("R4 both mode rise", irq[5], 1);
    rreg(2'd0, 3'd5, d); chk("R2 captured timer B", d, 16'h0222);
    clr(8'h20);
    set_b(16'h0223);
    pin_in[5] = 1'b0; tick(3);
    chk("R4 both mode fall", irq[5], 1);
    rreg(2'd0, 3'd5, d); chk("R4 both mode value", d, 16'h0223);
    wreg(2'd1, 3'd6, 16'h0002);
    pin_in[6] = 1'b1; tick(4);
    chk("R4 rise ignored in fall mode", irq[6], 0);
    set_a(16'h0177);
    pin_in[6] = 1'b0; tick(3);
    chk("R4 fall capture", irq[6], 1);
    rreg(2'd0, 3'd6, d); chk("R4 fall value", d, 16'h0177);
  endtask

  task automatic t_pair();
    wreg(2'd0, 3'd0, 16'h0070);
    wreg(2'd1, 3'd0, 16'h0015);
    wreg(2'd0, 3'd4, 16'h0080);
    wreg(2'd1, 3'd4, 16'h000C);
    chk("R10 upper oe off", pin_oe[4], 0);
    chk("R10 lower oe on", pin_oe[0], 1);
    set_a(16'h0070);
    chk("R10 lower match toggles", pin_out[0], 1);
    set_b(16'h0080);
    chk("R10 upper match toggles lower pin", pin_out[0], 0);
    chk("R10 upper pin quiet", pin_out[4], 0);
    set_a(16'h0071); set_b(16'h0081);
    ta = 16'h0070; tb = 16'h0080; tick();
    chk("R10 joint match single toggle", pin_out[0], 1);
  endtask

  task automatic t_sticky();
    clr(8'hFF);
    set_a(16'h0071);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'h0001; ta = 16'h0070;
    tick();
    wr_en = 1'b0;
    chk("R11 set wins over clear", irq[0], 1);
    set_a(16'h0071); set_a(16'h0070);
    clr(8'h02);
    chk("R11 other bit clear keeps flag", irq[0], 1);
    clr(8'h01);
    chk("R11 clear", irq[0], 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(3);
    rst = 1'b0;
    tick();
    t_reset();
    t_regs();
    t_cmp_evt();
    t_cmp_tgl();
    t_cmp_once();
    t_cmp_setclr();
    t_cfg();
    t_cap();
    t_pair();
    t_sticky();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule